// File: doc/BRIEF.md
# Multi-Wide Instruction Queue

This block is a circular buffer that sits between the decode and dispatch stages of a superscalar core. Each cycle the decode side offers a block of up to NFW decoded instructions, which are treated as opaque words of fixed width. The dispatch side sees the NFW oldest entries at the same time and reports how many of them it took.

A block is accepted only as a whole. If the free space cannot hold every instruction in the block, nothing is stored and the stall output tells decode to hold the block. Dispatch always takes an in-order prefix of the presented entries. It stops at the first instruction whose destination resource is full, so the younger entries stay queued behind that instruction. A flush, raised on a mispredicted branch, discards every queued entry.

A push and a pop may happen in the same cycle. The space check uses the occupancy at the start of the cycle, so entries popped in that cycle do not make room for the incoming block. The stall output depends combinationally on the offered mask and the stored occupancy.

Top module: `instq`

## Requirements
- R1: After reset the queue is empty: out_vld is all zeros, and in_stall is low even when a full block is offered.
- R2: The block size is the number of consecutive set bits of in_vld counted from slot 0. in_stall is high exactly when the block size exceeds LIQ minus the occupancy at the start of the cycle.
- R3: When in_stall is low and flush is low, the block's instructions are appended in slot order (slot 0 first). When in_stall is high, nothing is appended.
- R4: out_vld has bit i set exactly when more than i entries are stored. out_data slot i carries the i-th oldest entry.
- R5: out_take = k removes the k oldest entries. A k larger than the number of stored entries removes all of them.
- R6: A push and a pop in the same cycle both take effect. A full queue still stalls a full-width block even while NFW entries are being taken.
- R7: flush empties the queue by the next cycle and discards any block offered in the same cycle.
- R8: Slots after the first clear bit of in_vld are ignored. An all-zero mask stores nothing and never stalls, even when the queue is full.
- R9: The occupancy never exceeds LIQ. At full occupancy, any non-empty block stalls and the stored entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every stored entry |
| in_vld | input | NFW | Per-slot valid mask of the offered block |
| in_data | input | NFW*W | Offered instructions, slot i in bits [i*W +: W] |
| in_stall | output | 1 | The offered block does not fit and was not stored |
| out_vld | output | NFW | Per-slot valid mask of the oldest entries |
| out_data | output | NFW*W | Oldest entries, slot i in bits [i*W +: W] |
| out_take | input | $clog2(NFW+1) | Number of presented entries consumed this cycle |

## Verification
The hardest case to reach is a full-width block arriving while the queue is full and dispatch is draining NFW entries in the same cycle. The stall must follow the pre-pop occupancy, and the read index must still wrap correctly. The bench reaches this and every neighbouring case with a sweep. For each mask value, consume count and fill level from 0 to LIQ, it first flushes and then fills the queue one entry at a time to that level. This lands the head and tail pointers at varied wrap positions. It then applies the mask and consume count together and compares the result against a queue model.

// File: rtl/instq.sv
module instq #(
  parameter int W   = 32,
  parameter int NFW = 4,
  parameter int LIQ = 8,
  localparam int KW = $clog2(NFW + 1),
  localparam int PW = $clog2(LIQ),
  localparam int CW = $clog2(LIQ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [NFW-1:0]   in_vld,
  input  logic [NFW*W-1:0] in_data,
  output logic             in_stall,
  output logic [NFW-1:0]   out_vld,
  output logic [NFW*W-1:0] out_data,
  input  logic [KW-1:0]    out_take
);

  logic [W-1:0]  mem [LIQ];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] occ;
  logic [KW-1:0] blk_n;
  logic [CW-1:0] pop_n;
  logic          push;

  function automatic logic [PW-1:0] wrap(input int x);
    return (x >= LIQ) ? PW'(x - LIQ) : PW'(x);
  endfunction

  always_comb begin
    logic run;
    run   = 1'b1;
    blk_n = '0;
    for (int i = 0; i < NFW; i++) begin
      if (run && in_vld[i]) blk_n = blk_n + 1'b1;
      else run = 1'b0;
    end
  end

  assign in_stall = CW'(blk_n) > (CW'(LIQ) - occ);
  assign push     = !flush && (blk_n != '0) && !in_stall;
  assign pop_n    = (CW'(out_take) > occ) ? occ : CW'(out_take);

  for (genvar i = 0; i < NFW; i++) begin : g_out
    assign out_vld[i]          = CW'(i) < occ;
    assign out_data[i*W +: W]  = mem[wrap(int'(head) + i)];
  end

  always_ff @(posedge clk) begin
    if (push) begin
      for (int i = 0; i < NFW; i++)
        if (KW'(i) < blk_n) mem[wrap(int'(tail) + i)] <= in_data[i*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      head <= wrap(int'(head) + int'(pop_n));
      if (push) tail <= wrap(int'(tail) + int'(blk_n));
      occ  <= occ + (push ? CW'(blk_n) : CW'(0)) - pop_n;
    end
  end

endmodule

// File: rtl/instq_chk.sv
module instq_chk #(
  parameter int NFW = 4,
  parameter int LIQ = 8,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           flush,
  input logic           in_stall,
  input logic [NFW-1:0] out_vld,
  input logic [CW-1:0]  occ
);

  assert_empty_after_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0));

  assert_vld_prefix_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((({1'b0, out_vld} + 1'b1) & {1'b0, out_vld}) == '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= LIQ);

  assert_stall_needs_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_stall |-> (LIQ - int'(occ)) < NFW);

  assert_stall_no_growth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stall && !flush) |=> occ <= $past(occ));

  assert_empty_no_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !in_stall);

endmodule

bind instq instq_chk #(.NFW(NFW), .LIQ(LIQ), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_stall(in_stall),
  .out_vld(out_vld), .occ(occ)
);

// File: tb/instq_bench.sv
`timescale 1ns/1ps
module instq_bench;
  localparam int W = 32, NFW = 4, LIQ = 8;

  logic clk = 0, rst_n = 0, flush = 0;
  logic [NFW-1:0] in_vld = '0;
  logic [NFW*W-1:0] in_data = '0;
  logic [2:0] out_take = '0;
  logic in_stall;
  logic [NFW-1:0] out_vld;
  logic [NFW*W-1:0] out_data;

  int n_chk = 0, n_fail = 0;
  int q[$];
  int seq = 1;

  always #2.5 clk = ~clk;

  instq #(.W(W), .NFW(NFW), .LIQ(LIQ)) u_instq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_vld(in_vld), .in_data(in_data),
    .in_stall(in_stall), .out_vld(out_vld), .out_data(out_data), .out_take(out_take));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NFW-1:0] m, input int t, input bit f);
    int n, k, fr;
    bit st, run;
    logic [NFW-1:0] ev;
    @(negedge clk);
    n = 0; run = 1;
    for (int i = 0; i < NFW; i++) begin
      if (run && m[i]) n++; else run = 0;
    end
    for (int i = 0; i < NFW; i++)
      in_data[i*W +: W] = (i < n) ? W'(seq + i) : W'(32'hBAD00000 + i);
    in_vld = m; out_take = 3'(t); flush = f;
    #1;
    fr = LIQ - q.size();
    st = n > fr;
    chk(in_stall == st, "R2 stall", int'(in_stall), int'(st));
    for (int i = 0; i < NFW; i++) ev[i] = i < q.size();
    chk(out_vld == ev, "R4 out_vld", int'(out_vld), int'(ev));
    for (int i = 0; i < NFW; i++)
      if (i < q.size())
        chk(out_data[i*W +: W] == W'(q[i]), "R3 order", int'(out_data[i*W +: W]), q[i]);
    @(posedge clk);
    if (f) q.delete();
    else begin
      k = (t > q.size()) ? q.size() : t;
      for (int i = 0; i < k; i++) void'(q.pop_front());
      if (!st) for (int i = 0; i < n; i++) q.push_back(seq + i);
    end
    seq += NFW;
    #1;
    in_vld = '0; out_take = '0; flush = 0;
  endtask

  task automatic peek();
    @(negedge clk); #1;
  endtask

  task automatic fill_to(input int lvl);
    step('0, 0, 1);
    for (int i = 0; i < lvl; i++) step(4'b0001, 0, 0);
  endtask

  initial begin
    #900000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int first;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    in_vld = 4'hF; #1;
    chk(out_vld == '0, "R1 out_vld", int'(out_vld), 0);
    chk(in_stall == 1'b0, "R1 stall", int'(in_stall), 0);
    in_vld = '0;

    for (int m = 0; m < 16; m++)
      for (int t = 0; t <= NFW; t++)
        for (int lvl = 0; lvl <= LIQ; lvl++) begin
          fill_to(lvl);
          step(4'(m), t, 0);
          step('0, 0, 0);
        end

    fill_to(2);
    step('0, 4, 0);
    peek();
    chk(out_vld == '0, "R5 clamp", int'(out_vld), 0);

    fill_to(6);
    first = q[2];
    step('0, 2, 0);
    peek();
    chk(out_data[W-1:0] == W'(first), "R5 take2", int'(out_data[W-1:0]), first);

    fill_to(LIQ);
    first = q[4];
    step(4'hF, 4, 0);
    peek();
    chk(out_vld == 4'hF, "R6 vld", int'(out_vld), 15);
    chk(out_data[W-1:0] == W'(first), "R6 head", int'(out_data[W-1:0]), first);
    step('0, 4, 0);
    peek();
    chk(out_vld == '0, "R6 no push", int'(out_vld), 0);

    fill_to(5);
    step(4'b0001, 0, 1);
    peek();
    chk(out_vld == '0, "R7 flush", int'(out_vld), 0);

    fill_to(0);
    first = seq;
    step(4'b0101, 0, 0);
    peek();
    chk(out_vld == 4'b0001, "R8 vld", int'(out_vld), 1);
    chk(out_data[W-1:0] == W'(first), "R8 data", int'(out_data[W-1:0]), first);

    fill_to(LIQ);
    @(negedge clk); in_vld = '0; #1;
    chk(in_stall == 1'b0, "R8 zero mask", int'(in_stall), 0);
    in_vld = 4'b0001; #1;
    chk(in_stall == 1'b1, "R9 full stall", int'(in_stall), 1);
    in_vld = '0;
    first = q[0];
    step(4'b0001, 0, 0);
    peek();
    chk(out_data[W-1:0] == W'(first), "R9 unchanged", int'(out_data[W-1:0]), first);
    step('0, 4, 0);
    step('0, 4, 0);
    peek();
    chk(out_vld == '0, "R9 count", int'(out_vld), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule